// File: doc/BRIEF.md
# If-Then conditional block tracker

This block follows an If-Then block through the instruction stream. When an IT instruction retires, a load offer carries a 4-bit base condition code, a block length of one to `MAX_SLOTS` instructions, and a per-slot polarity pattern. Each polarity bit chooses one of two conditions for its slot. A clear bit selects the base condition ("then"). A set bit selects the exact inverse of the base condition ("else"). For the instruction in the current slot, the block outputs the effective condition code. It also evaluates that code against the N, Z, C and V flags and produces an execute/skip signal.

Each retired instruction pulses `adv_i`, which moves the tracker on by one slot. The tracker goes idle after the final slot retires, or at once on a flush. Outside a block, the current condition reads as "always" and execute is high. The tracker state belongs to the processor's execution state. Software cannot see it and cannot write it, so the block has no register access.

The load offer is a valid/ready interface with no buffering. `ld_ready_o` is high only while no block is active. An offer made while ready is low is not held for later: it is dropped and flagged on `ld_err_o` in the same cycle. An offer with an illegal encoding is also dropped and flagged. A flush in the same cycle drops an offer silently.

Top module: `it_block_tracker`

## Requirements
- R1: After reset, `in_blk_o`=0, `cur_cond_o`=4'hE (always), `exec_o`=1 and `ld_ready_o`=1.
- R2: An accepted load puts `in_blk_o`=1 from the next cycle, with slot 0 using the base condition. Bit 0 of `ld_pol_i` is ignored.
- R3: For slot k (k≥1), `cur_cond_o` equals the base condition when `ld_pol_i[k]`=0. When `ld_pol_i[k]`=1, it equals the base condition with bit 0 inverted.
- R4: Each `adv_i` pulse during a block moves to the next slot. After `ld_len_i` pulses, `in_blk_o` returns to 0. `adv_i` has no effect while idle.
- R5: `flush_i` clears the block in the next cycle and takes priority over `adv_i`. An offer made in a flush cycle is dropped without `ld_err_o`.
- R6: `exec_o` follows the condition table for 0..14, where N,Z,C,V are `flags_i[3:0]` in that order. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always 1.
- R7: While a block is active, `ld_ready_o`=0. An offer in that state raises `ld_err_o` in the same cycle and leaves the slot sequence unchanged.
- R8: An offer with length 0, length above `MAX_SLOTS`, condition 4'hF, or condition 4'hE with any polarity bit set in slots 1..len-1 raises `ld_err_o` and is ignored.
- R9: While idle, `cur_cond_o`=4'hE and `exec_o`=1 for any flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Load offer from a retiring IT instruction |
| ld_ready_o | output | 1 | Tracker idle, offer can be accepted |
| ld_cond_i | input | 4 | Base condition code |
| ld_len_i | input | LW | Number of instructions in the block |
| ld_pol_i | input | MAX_SLOTS | Per-slot else bit (bit 0 ignored) |
| ld_err_o | output | 1 | Offer rejected (busy or illegal) this cycle |
| adv_i | input | 1 | One instruction retired |
| flush_i | input | 1 | Pipeline flush, abandon block |
| flags_i | input | 4 | N,Z,C,V flags |
| in_blk_o | output | 1 | A block is active |
| cur_cond_o | output | 4 | Effective condition of the current slot |
| exec_o | output | 1 | Current slot's instruction executes |

## Verification
The bench builds the tracker with the default `MAX_SLOTS`=4, which makes `ld_len_i` 3 bits wide. At that width the bench can offer lengths 5 to 7, which are out of range, and so reach the rejection path. It also runs four-slot blocks that use every polarity position. With the length fixed at one slot, every condition code from 0 to 14 is evaluated against all sixteen flag combinations.

// File: rtl/it_pkg.sv
package it_pkg;
  localparam int CW = 4;
  localparam int FW = 4;
  localparam logic [CW-1:0] COND_AL  = 4'hE;
  localparam logic [CW-1:0] COND_BAD = 4'hF;
endpackage

// File: rtl/it_load_check.sv
module it_load_check
  import it_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int LW = $clog2(MAX_SLOTS + 1)
) (
  input  logic [CW-1:0]        cond_i,
  input  logic [LW-1:0]        len_i,
  input  logic [MAX_SLOTS-1:0] pol_i,
  output logic                 bad_o
);
  logic [MAX_SLOTS-1:0] live_else;

  // An else slot counts only if it lies inside the block; slot 0 is always then.
  genvar g;
  generate
    for (g = 0; g < MAX_SLOTS; g++) begin : g_slot
      if (g == 0) begin : g_first
        assign live_else[g] = 1'b0;
      end else begin : g_rest
        assign live_else[g] = pol_i[g] && (LW'(g) < len_i);
      end
    end
  endgenerate

  always_comb begin
    bad_o = 1'b0;
    if (len_i == '0) bad_o = 1'b1;
    if (len_i > LW'(MAX_SLOTS)) bad_o = 1'b1;
    if (cond_i == COND_BAD) bad_o = 1'b1;
    if (cond_i == COND_AL && |live_else) bad_o = 1'b1;
  end
endmodule

// File: rtl/it_slot_state.sv
module it_slot_state
  import it_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int LW = $clog2(MAX_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [CW-1:0]        cond_i,
  input  logic [LW-1:0]        len_i,
  input  logic [MAX_SLOTS-1:0] pol_i,
  input  logic                 adv_i,
  input  logic                 flush_i,
  output logic                 in_blk_o,
  output logic [CW-1:0]        cur_cond_o
);
  logic [LW-1:0]        rem_q;
  logic [CW-1:0]        base_q;
  logic [MAX_SLOTS-1:0] pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      base_q <= COND_AL;
      pol_q  <= '0;
    end else if (flush_i) begin
      rem_q <= '0;
      pol_q <= '0;
    end else if (load_i) begin
      rem_q  <= len_i;
      base_q <= cond_i;
      pol_q  <= {pol_i[MAX_SLOTS-1:1], 1'b0};
    end else if (adv_i && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
      pol_q <= pol_q >> 1;
    end
  end

  assign in_blk_o   = (rem_q != '0);
  assign cur_cond_o = in_blk_o ? (base_q ^ {{(CW-1){1'b0}}, pol_q[0]}) : COND_AL;

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> rem_q == '0); // R5
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk_o && adv_i && !flush_i) |=> rem_q == $past(rem_q) - 1'b1); // R4
  AST_LOAD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !flush_i) |=> (rem_q == $past(len_i)) && (cur_cond_o == $past(cond_i))); // R2
  AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk_o && !adv_i && !flush_i) |=> $stable(rem_q) && $stable(cur_cond_o)); // R7
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= LW'(MAX_SLOTS)); // R4
endmodule

// File: rtl/it_cond_eval.sv
module it_cond_eval
  import it_pkg::*;
(
  input  logic [CW-1:0] cond_i,
  input  logic [FW-1:0] flags_i,
  output logic          pass_o
);
  logic n, z, c, v, raw;
  assign {n, z, c, v} = flags_i;

  // Codes pair up: the upper three bits pick a test, bit 0 inverts it.
  always_comb begin
    unique case (cond_i[3:1])
      3'd0: raw = z;
      3'd1: raw = c;
      3'd2: raw = n;
      3'd3: raw = v;
      3'd4: raw = c & ~z;
      3'd5: raw = (n == v);
      3'd6: raw = ~z & (n == v);
      default: raw = 1'b1;
    endcase
    pass_o = (cond_i[3:1] == 3'd7) ? 1'b1 : (raw ^ cond_i[0]);
  end

  always_comb begin
    AST_AL_EXECUTES: assert (cond_i != COND_AL || pass_o); // R6
  end
endmodule

// File: rtl/it_block_tracker.sv
module it_block_tracker
  import it_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int LW = $clog2(MAX_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid_i,
  output logic                 ld_ready_o,
  input  logic [3:0]           ld_cond_i,
  input  logic [LW-1:0]        ld_len_i,
  input  logic [MAX_SLOTS-1:0] ld_pol_i,
  output logic                 ld_err_o,
  input  logic                 adv_i,
  input  logic                 flush_i,
  input  logic [3:0]           flags_i,
  output logic                 in_blk_o,
  output logic [3:0]           cur_cond_o,
  output logic                 exec_o
);
  logic bad;
  logic accept;

  it_load_check #(.MAX_SLOTS(MAX_SLOTS)) u_check (
    .cond_i (ld_cond_i),
    .len_i  (ld_len_i),
    .pol_i  (ld_pol_i),
    .bad_o  (bad)
  );

  assign ld_ready_o = ~in_blk_o;
  assign accept     = ld_valid_i & ld_ready_o & ~bad & ~flush_i;
  assign ld_err_o   = ld_valid_i & ~flush_i & (in_blk_o | bad);

  it_slot_state #(.MAX_SLOTS(MAX_SLOTS)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .cond_i     (ld_cond_i),
    .len_i      (ld_len_i),
    .pol_i      (ld_pol_i),
    .adv_i      (adv_i),
    .flush_i    (flush_i),
    .in_blk_o   (in_blk_o),
    .cur_cond_o (cur_cond_o)
  );

  it_cond_eval u_eval (
    .cond_i  (cur_cond_o),
    .flags_i (flags_i),
    .pass_o  (exec_o)
  );

  AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_err_o && !in_blk_o) |=> !in_blk_o); // R8
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && in_blk_o && !adv_i && !flush_i) |=> $stable(cur_cond_o)); // R7
  AST_IDLE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_blk_o |-> exec_o); // R9
endmodule

// File: tb/tb_it_block_tracker.sv
module tb_it_block_tracker;
  localparam int MAX_SLOTS = 4;
  localparam int LW = $clog2(MAX_SLOTS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [3:0] ld_cond = 4'h0;
  logic [LW-1:0] ld_len = '0;
  logic [MAX_SLOTS-1:0] ld_pol = '0;
  logic ld_err;
  logic adv = 1'b0;
  logic flush = 1'b0;
  logic [3:0] flags = 4'h0;
  logic in_blk;
  logic [3:0] cur_cond;
  logic exec;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  it_block_tracker #(.MAX_SLOTS(MAX_SLOTS)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_valid), .ld_ready_o(ld_ready),
    .ld_cond_i(ld_cond), .ld_len_i(ld_len), .ld_pol_i(ld_pol), .ld_err_o(ld_err),
    .adv_i(adv), .flush_i(flush), .flags_i(flags), .in_blk_o(in_blk),
    .cur_cond_o(cur_cond), .exec_o(exec)
  );

  function automatic bit ref_exec(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Offer a load for one cycle; ld_err is sampled mid-cycle, state after the edge.
  task automatic offer(input logic [3:0] cc, input logic [LW-1:0] len,
                       input logic [MAX_SLOTS-1:0] pol, input bit exp_err, input string req);
    @(posedge clk); #2;
    ld_valid = 1'b1; ld_cond = cc; ld_len = len; ld_pol = pol;
    @(negedge clk);
    chk(req, ld_err, exp_err);
    @(posedge clk); #2;
    ld_valid = 1'b0;
  endtask

  task automatic pulse_adv();
    @(posedge clk); #2; adv = 1'b1;
    @(posedge clk); #2; adv = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in_blk", in_blk, 0);
    chk("R1 cur_cond", cur_cond, 4'hE);
    chk("R1 exec", exec, 1);
    chk("R1 ld_ready", ld_ready, 1);
  endtask

  task automatic t_idle();
    for (int f = 0; f < 16; f++) begin
      flags = f[3:0];
      #1;
      chk("R9 idle exec", exec, 1);
      chk("R9 idle cond", cur_cond, 4'hE);
    end
    pulse_adv();
    @(negedge clk);
    chk("R4 adv idle no effect", in_blk, 0);
  endtask

  task automatic t_all_then();
    offer(4'd2, 3'd3, 4'b0001, 0, "R2 accept");
    @(negedge clk);
    chk("R2 in_blk", in_blk, 1);
    chk("R2 slot0 cond", cur_cond, 4'd2);
    chk("R7 ready low", ld_ready, 0);
    for (int k = 1; k < 3; k++) begin
      pulse_adv();
      @(negedge clk);
      chk("R3 then slot", cur_cond, 4'd2);
      chk("R4 still in", in_blk, 1);
    end
    pulse_adv();
    @(negedge clk);
    chk("R4 end of block", in_blk, 0);
    chk("R4 idle cond", cur_cond, 4'hE);
  endtask

  task automatic t_mixed();
    logic [3:0] exp_c [4];
    exp_c[0] = 4'd0; exp_c[1] = 4'd1; exp_c[2] = 4'd0; exp_c[3] = 4'd1;
    flags = 4'b0100;
    offer(4'd0, 3'd4, 4'b1010, 0, "R2 accept mixed");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 slot cond", cur_cond, exp_c[k]);
      chk("R6 slot exec", exec, ref_exec(exp_c[k], flags));
      pulse_adv();
    end
    @(negedge clk);
    chk("R4 four slots done", in_blk, 0);
  endtask

  task automatic t_table();
    for (int cc = 0; cc < 15; cc++) begin
      offer(cc[3:0], 3'd1, 4'b0000, 0, "R6 load");
      for (int f = 0; f < 16; f++) begin
        flags = f[3:0];
        #1;
        chk("R6 exec", exec, ref_exec(cc[3:0], f[3:0]));
      end
      pulse_adv();
    end
  endtask

  task automatic t_busy();
    offer(4'd10, 3'd2, 4'b0010, 0, "R2 accept");
    offer(4'd4, 3'd4, 4'b0000, 1, "R7 busy err");
    @(negedge clk);
    chk("R7 cond unchanged", cur_cond, 4'd10);
    pulse_adv();
    @(negedge clk);
    chk("R7 old seq slot1", cur_cond, 4'd11);
    pulse_adv();
    @(negedge clk);
    chk("R7 old seq ends", in_blk, 0);
  endtask

  task automatic t_bad();
    offer(4'd1, 3'd0, 4'b0000, 1, "R8 len0 err");
    @(negedge clk); chk("R8 len0 ignored", in_blk, 0);
    offer(4'd1, 3'd5, 4'b0000, 1, "R8 len5 err");
    @(negedge clk); chk("R8 len5 ignored", in_blk, 0);
    offer(4'hF, 3'd2, 4'b0000, 1, "R8 cond F err");
    @(negedge clk); chk("R8 cond F ignored", in_blk, 0);
    offer(4'hE, 3'd2, 4'b0010, 1, "R8 AL else err");
    @(negedge clk); chk("R8 AL else ignored", in_blk, 0);
    offer(4'hE, 3'd2, 4'b0101, 0, "R8 AL else outside len ok");
    @(negedge clk); chk("R8 AL legal entered", in_blk, 1);
    @(posedge clk); #2; flush = 1'b1;
    @(posedge clk); #2; flush = 1'b0;
  endtask

  task automatic t_flush();
    offer(4'd8, 3'd4, 4'b0000, 0, "R2 accept");
    @(posedge clk); #2; flush = 1'b1; adv = 1'b1;
    @(posedge clk); #2; flush = 1'b0; adv = 1'b0;
    @(negedge clk);
    chk("R5 flush clears", in_blk, 0);
    @(posedge clk); #2; flush = 1'b1; ld_valid = 1'b1; ld_cond = 4'd3; ld_len = 3'd2; ld_pol = '0;
    @(negedge clk);
    chk("R5 no err on flush", ld_err, 0);
    @(posedge clk); #2; flush = 1'b0; ld_valid = 1'b0;
    @(negedge clk);
    chk("R5 offer dropped", in_blk, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_idle();
    t_all_then();
    t_mixed();
    t_table();
    t_busy();
    t_bad();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule